// File: doc/BRIEF.md
# Raster Vertical Position Counter

This block tracks the current scanline of a raster frame. From it, the block derives the 8-bit vertical position value that a video processor lets a CPU read. A line strobe advances the internal line number by one. A frame strobe returns it to zero. The frame geometry follows two selects: a 50/60 Hz standard select and a tall-screen select. Frames are 262 or 312 lines long, and the active area is 224 or 240 lines.

The readable counter is not the raw line number, for two reasons. Once the frame is well into blanking, the counter steps backwards by an amount that depends on the standard, so it fits 8 bits. In the double-resolution interlace mode, the counter is re-encoded: the line number is shifted left and the overflow bit moves into bit 0. The block also drives a vertical-blank flag, a sticky pending-interrupt flag, and a one-cycle interrupt pulse gated by an enable input. The pulse is raised on the first line after the active area.

The mode selects take effect only at a frame strobe. The rest of the video pipeline feeds the block from its horizontal timing, one strobe per scanline.

Top module: `vcnt_raster`

## Requirements
- R1: `line_num` steps by one on each `line_stb` up to the last line of the frame, which is 261 when the standard select is 0 and 311 when it is 1. A `line_stb` on the last line leaves `line_num` and `vcount` unchanged.
- R2: A `frame_stb` sets `line_num` and `vcount` to 0 and clears `vblank` and `vint_pending` on the next clock edge. It wins over a simultaneous `line_stb`.
- R3: The active area is 240 lines when both `pal_sel` and `tall_sel` are 1 at frame start, and 224 lines otherwise. `vblank` is 1 exactly on lines at or beyond the active count.
- R4: With `ilace_sel` 0, on an active line `vcount` equals the low 8 bits of the line number.
- R5: With `ilace_sel` 0, on a blanking line after the first one, `vcount` is the low 8 bits of w. w is the line number minus 6 once the line reaches 235 (standard 0), or minus 56 once it reaches 259 (standard 1). Below those lines, w is the line number unchanged.
- R6: With `ilace_sel` 1, on an active line `vcount` is {line[6:0], line[7]}.
- R7: With `ilace_sel` 1, on a blanking line after the first one, `vcount` is {w[6:0], 1}, with w as in R5.
- R8: On the first blanking line (line number equal to the active count), `vcount` is 0xE0, or 0xC1 with `ilace_sel` 1.
- R9: When the line number reaches the active count, `vint_pending` is set and stays set until the next frame strobe. In that same cycle, `vint_pulse` is high for exactly one clock, and only if `vint_en` is 1.
- R10: `pal_sel`, `tall_sel` and `ilace_sel` are sampled only on a `frame_stb`. Changes during a frame have no effect until the next frame strobe.
- R11: A synchronous active-high `rst` sets `line_num` and `vcount` to 0, drives all flags low, and selects the 60 Hz geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | Advance one scanline (one-cycle strobe) |
| frame_stb | input | 1 | Start a new frame (one-cycle strobe) |
| pal_sel | input | 1 | 1 selects 312-line frames, 0 selects 262 |
| tall_sel | input | 1 | Requests the 240-line active area (50 Hz only) |
| ilace_sel | input | 1 | Double-resolution interlace encoding of the counter |
| vint_en | input | 1 | Lets the vertical interrupt pulse out |
| vcount | output | 8 | CPU-visible vertical position |
| line_num | output | 9 | Internal line number |
| vblank | output | 1 | Vertical blank in progress |
| vint_pending | output | 1 | Vertical interrupt recorded this frame |
| vint_pulse | output | 1 | One-cycle vertical interrupt request |

## Verification
The embedded properties check the structural behaviour on every cycle. These are: the line number stays within range, steps by one or holds at the last line, and clears on a frame strobe. The modes are stable between frame strobes. The interrupt pulse appears only at the rising edge of blanking and only with the enable high. The first blanking code is correct, and the interlace blanking codes are odd. The exact counter value on every line, including the backward jump and the interlace rotation, can only be shown by the bench. The bench walks complete frames in each standard and mode against an independent model. It also shows that a mode change in mid-frame is ignored and that a frame strobe wins over a simultaneous line strobe.

// File: rtl/vcnt_pkg.sv
package vcnt_pkg;

    localparam int LINE_W      = 9;
    localparam int CNT_W       = 8;
    localparam int LINES_60    = 262;
    localparam int LINES_50    = 312;
    localparam int ACT_SHORT   = 224;
    localparam int ACT_TALL    = 240;
    localparam int WRAP_AT_60  = 235;
    localparam int WRAP_AT_50  = 259;
    localparam int BACK_60     = 6;
    localparam int BACK_50     = 56;
    localparam int EDGE_CODE   = 8'hE0;
    localparam int EDGE_CODE_I = 8'hC1;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [CNT_W-1:0]  vcnt_t;

    typedef struct packed {
        logic pal;
        logic tall;
        logic il2;
    } vmode_t;

    function automatic line_t last_of(input vmode_t m);
        return m.pal ? line_t'(LINES_50 - 1) : line_t'(LINES_60 - 1);
    endfunction

    function automatic line_t active_of(input vmode_t m);
        return (m.pal && m.tall) ? line_t'(ACT_TALL) : line_t'(ACT_SHORT);
    endfunction

    function automatic line_t wrapped(input line_t l, input vmode_t m);
        line_t w;
        w = l;
        if (m.pal && (l >= line_t'(WRAP_AT_50)))
            w = l - line_t'(BACK_50);
        else if (!m.pal && (l >= line_t'(WRAP_AT_60)))
            w = l - line_t'(BACK_60);
        return w;
    endfunction

    function automatic vcnt_t encode(input line_t l, input vmode_t m);
        line_t act;
        line_t w;
        vcnt_t v;
        act = active_of(m);
        w   = wrapped(l, m);
        if (l < act)
            v = m.il2 ? {l[CNT_W-2:0], l[CNT_W-1]} : l[CNT_W-1:0];
        else if (l == act)
            v = m.il2 ? vcnt_t'(EDGE_CODE_I) : vcnt_t'(EDGE_CODE);
        else
            v = m.il2 ? {w[CNT_W-2:0], 1'b1} : w[CNT_W-1:0];
        return v;
    endfunction

endpackage

// File: rtl/vcnt_mode_latch.sv
module vcnt_mode_latch
    import vcnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_stb,
    input  vmode_t mode_in,
    output vmode_t mode_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (frame_stb)
            mode_q <= mode_in;
    end

    // R10: geometry only changes at a frame boundary
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(mode_q));

endmodule

// File: rtl/vcnt_line_ctr.sv
module vcnt_line_ctr
    import vcnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_stb,
    input  logic   line_stb,
    input  vmode_t mode_q,
    output line_t  line_q,
    output line_t  line_nxt,
    output logic   adv
);

    line_t last;

    always_comb begin
        last = last_of(mode_q);
        adv  = frame_stb | (line_stb & (line_q != last));
        if (frame_stb)
            line_nxt = '0;
        else if (adv)
            line_nxt = line_q + line_t'(1);
        else
            line_nxt = line_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            line_q <= '0;
        else
            line_q <= line_nxt;
    end

    p_line_range_r1: assert property (@(posedge clk) disable iff (rst)
        line_q <= last_of(mode_q));

    p_line_step_r1: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !frame_stb && line_q != last_of(mode_q))
        |=> line_q == line_t'($past(line_q) + line_t'(1)));

    p_line_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !frame_stb && line_q == last_of(mode_q)) |=> $stable(line_q));

    p_line_clear_r2: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> line_q == '0);

endmodule

// File: rtl/vcnt_encode.sv
module vcnt_encode
    import vcnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_stb,
    input  logic   adv,
    input  line_t  line_nxt,
    input  vmode_t mode_q,
    output vcnt_t  vcount
);

    always_ff @(posedge clk) begin
        if (rst)
            vcount <= '0;
        else if (frame_stb)
            vcount <= '0;
        else if (adv)
            vcount <= encode(line_nxt, mode_q);
    end

endmodule

// File: rtl/vcnt_blank_irq.sv
module vcnt_blank_irq
    import vcnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_stb,
    input  logic   adv,
    input  line_t  line_nxt,
    input  vmode_t mode_q,
    input  logic   vint_en,
    output logic   vblank,
    output logic   vint_pending,
    output logic   vint_pulse
);

    line_t act;
    logic  enter_blank;

    always_comb begin
        act         = active_of(mode_q);
        enter_blank = adv && !frame_stb && (line_nxt == act);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vblank       <= 1'b0;
            vint_pending <= 1'b0;
            vint_pulse   <= 1'b0;
        end else begin
            vint_pulse <= 1'b0;
            if (frame_stb) begin
                vblank       <= 1'b0;
                vint_pending <= 1'b0;
            end else if (adv && (line_nxt >= act)) begin
                vblank <= 1'b1;
                if (enter_blank) begin
                    vint_pending <= 1'b1;
                    vint_pulse   <= vint_en;
                end
            end
        end
    end

    p_frame_clear_r2: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> (!vblank && !vint_pending));

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
        vint_pulse |=> !vint_pulse);

endmodule

// File: rtl/vcnt_raster.sv
module vcnt_raster
    import vcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_stb,
    input  logic              frame_stb,
    input  logic              pal_sel,
    input  logic              tall_sel,
    input  logic              ilace_sel,
    input  logic              vint_en,
    output logic [CNT_W-1:0]  vcount,
    output logic [LINE_W-1:0] line_num,
    output logic              vblank,
    output logic              vint_pending,
    output logic              vint_pulse
);

    vmode_t mode_in;
    vmode_t mode_q;
    line_t  line_q;
    line_t  line_nxt;
    logic   adv;
    vcnt_t  vcount_q;

    assign mode_in = '{pal: pal_sel, tall: tall_sel, il2: ilace_sel};

    vcnt_mode_latch u_mode (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .mode_in   (mode_in),
        .mode_q    (mode_q)
    );

    vcnt_line_ctr u_line (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .line_stb  (line_stb),
        .mode_q    (mode_q),
        .line_q    (line_q),
        .line_nxt  (line_nxt),
        .adv       (adv)
    );

    vcnt_encode u_enc (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .adv       (adv),
        .line_nxt  (line_nxt),
        .mode_q    (mode_q),
        .vcount    (vcount_q)
    );

    vcnt_blank_irq u_blank (
        .clk          (clk),
        .rst          (rst),
        .frame_stb    (frame_stb),
        .adv          (adv),
        .line_nxt     (line_nxt),
        .mode_q       (mode_q),
        .vint_en      (vint_en),
        .vblank       (vblank),
        .vint_pending (vint_pending),
        .vint_pulse   (vint_pulse)
    );

    assign vcount   = vcount_q;
    assign line_num = line_q;

    // R3: blanking flag agrees with the line counter
    p_blank_region_r3: assert property (@(posedge clk) disable iff (rst)
        vblank == (line_q >= active_of(mode_q)));

    p_edge_code_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(vblank) |-> vcount_q == (mode_q.il2 ? vcnt_t'(EDGE_CODE_I) : vcnt_t'(EDGE_CODE)));

    p_il_blank_odd_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q.il2 && vblank && line_q != active_of(mode_q)) |-> vcount_q[0]);

    p_pulse_edge_r9: assert property (@(posedge clk) disable iff (rst)
        vint_pulse |-> ($rose(vblank) && vint_pending));

    p_pulse_gate_r9: assert property (@(posedge clk) disable iff (rst)
        vint_pulse |-> $past(vint_en));

endmodule

// File: tb/vcnt_raster_tb_top.sv
module vcnt_raster_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_stb = 1'b0;
    logic       frame_stb = 1'b0;
    logic       pal_sel = 1'b0;
    logic       tall_sel = 1'b0;
    logic       ilace_sel = 1'b0;
    logic       vint_en = 1'b0;
    logic [7:0] vcount;
    logic [8:0] line_num;
    logic       vblank;
    logic       vint_pending;
    logic       vint_pulse;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vcnt_raster dut_i (
        .clk          (clk),
        .rst          (rst),
        .line_stb     (line_stb),
        .frame_stb    (frame_stb),
        .pal_sel      (pal_sel),
        .tall_sel     (tall_sel),
        .ilace_sel    (ilace_sel),
        .vint_en      (vint_en),
        .vcount       (vcount),
        .line_num     (line_num),
        .vblank       (vblank),
        .vint_pending (vint_pending),
        .vint_pulse   (vint_pulse)
    );

    // {pal, tall, il, en, frame lines[8:0], active lines[8:0]}
    localparam logic [21:0] CFG [6] = '{
        {4'b0001, 9'd262, 9'd224},
        {4'b0100, 9'd262, 9'd224},
        {4'b0011, 9'd262, 9'd224},
        {4'b1001, 9'd312, 9'd224},
        {4'b1100, 9'd312, 9'd240},
        {4'b1111, 9'd312, 9'd240}
    };

    function automatic int ref_vc(int y, int pal, int act, int il);
        int v;
        if (y < act)
            v = il ? ((y << 1) | ((y << 1) >> 8)) : y;
        else if (y == act)
            v = il ? 'hC1 : 'hE0;
        else begin
            v = y;
            if (pal != 0 && y >= 259) v = v - 56;
            if (pal == 0 && y >= 235) v = v - 6;
            if (il) v = (v << 1) | 1;
        end
        return v & 255;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step_line();
        @(negedge clk) line_stb = 1'b1;
        @(negedge clk) line_stb = 1'b0;
    endtask

    task automatic start_frame();
        @(negedge clk) frame_stb = 1'b1;
        @(negedge clk) frame_stb = 1'b0;
    endtask

    task automatic step_to(input int target);
        while (int'(line_num) < target) step_line();
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11 line", int'(line_num), 0);
        chk("R11 vcount", int'(vcount), 0);
        chk("R11 flags", {vblank, vint_pending, vint_pulse}, 0);

        // vector table walk: full frames in each geometry and mode
        for (int c = 0; c < 6; c++) begin
            int pal, il, en, lines, act;
            pal   = int'(CFG[c][21]);
            il    = int'(CFG[c][19]);
            en    = int'(CFG[c][18]);
            lines = int'(CFG[c][17:9]);
            act   = int'(CFG[c][8:0]);
            pal_sel   = CFG[c][21];
            tall_sel  = CFG[c][20];
            ilace_sel = CFG[c][19];
            vint_en   = CFG[c][18];
            start_frame();
            chk("R2 line", int'(line_num), 0);
            chk("R2 vcount", int'(vcount), 0);
            chk("R2 flags", {vblank, vint_pending}, 0);
            for (int y = 1; y < lines; y++) begin
                string tag;
                step_line();
                if (y < act)       tag = il ? "R6" : "R4";
                else if (y == act) tag = "R8";
                else               tag = il ? "R7" : "R5";
                chk("R1 line", int'(line_num), y);
                chk(tag, int'(vcount), ref_vc(y, pal, act, il));
                chk("R3 vblank", int'(vblank), (y >= act) ? 1 : 0);
                chk("R9 pending", int'(vint_pending), (y >= act) ? 1 : 0);
                chk("R9 pulse", int'(vint_pulse), (y == act && en != 0) ? 1 : 0);
            end
            step_line();
            chk("R1 hold line", int'(line_num), lines - 1);
            chk("R1 hold vcount", int'(vcount), ref_vc(lines - 1, pal, act, il));
        end

        // R10: mode inputs changed mid-frame are ignored
        pal_sel = 1'b0; tall_sel = 1'b0; ilace_sel = 1'b0; vint_en = 1'b1;
        start_frame();
        step_to(100);
        pal_sel = 1'b1; tall_sel = 1'b1; ilace_sel = 1'b1;
        step_to(224);
        chk("R10 edge code", int'(vcount), 'hE0);
        chk("R10 vblank", int'(vblank), 1);
        step_to(235);
        chk("R10 wrap", int'(vcount), 'hE5);
        step_to(261);
        step_line();
        chk("R10 length", int'(line_num), 261);
        start_frame();
        step_to(262);
        chk("R10 new frame", int'(line_num), 262);
        step_to(240);
        chk("R10 new frame il", int'(vcount), ref_vc(262, 1, 240, 1));

        // R2: frame strobe wins over a line strobe
        start_frame();
        step_to(5);
        @(negedge clk) begin frame_stb = 1'b1; line_stb = 1'b1; end
        @(negedge clk) begin frame_stb = 1'b0; line_stb = 1'b0; end
        chk("R2 priority", int'(line_num), 0);

        // R11: reset in mid-frame
        pal_sel = 1'b0; tall_sel = 1'b0; ilace_sel = 1'b0;
        start_frame();
        step_to(230);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R11 mid line", int'(line_num), 0);
        chk("R11 mid vcount", int'(vcount), 0);
        chk("R11 mid flags", {vblank, vint_pending, vint_pulse}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule